// File: doc/BRIEF.md
# Grouped Interrupt Priority Arbiter

This block arbitrates interrupts for a single processor. From a parameterised set of sources, each one described by an enable, a pending flag, a per-processor target mask, an 8-bit priority and a group bit, it chooses the most urgent source that can be delivered. It publishes that source's ID and raises one of two request lines, a normal request or a fast request.

Which line is raised depends on the winner's group and on a fast-routing enable. Delivery is controlled in three ways. Group enables are held at two levels, distributor-wide and per-CPU. A priority mask limits which IDs are shown. The priority of the handler that is currently running limits which interrupts can preempt it.

Register programming, acknowledge and end-of-interrupt tracking sit outside this block. The block sees their results only as plain input levels.

Top module: `irq_prio_select`

## Requirements
- R1: Source i is a candidate only when its enable and pending bits are both 1. It must also either have an ID below 32, or have bit `CPU_IDX` set in its target field `src_targets[i*CPU_COUNT +: CPU_COUNT]`.
- R2: Among the candidates, the winner has the numerically smallest unsigned priority `src_prio[i*8 +: 8]`. When priorities are equal, the smallest ID wins.
- R3: When there is no candidate, the winning priority is taken as 256, and `pend_id` reads 1023 with both request lines low.
- R4: `pend_id` shows the winner's ID only when the winning priority is strictly below `prio_mask`. Otherwise it reads 1023 and neither request line is raised.
- R5: A request line is raised only when the winning priority is also strictly below `run_prio`. `run_prio` is 9 bits wide, and 256 means idle.
- R6: A winner in group g (its `src_group` bit, 0 or 1) needs both `dist_grp_en[g]` and `cpu_grp_en[g]` set before either request line can be raised. `pend_id` is not affected by these bits.
- R7: A deliverable winner in group 0 raises `fiq_o` when `fast_route_en` is 1. Every other deliverable winner raises `irq_o`. The two lines are never high together.
- R8: When `dist_grp_en` is 0, or when `cpu_grp_en` is 0, both request lines are low.
- R9: All outputs are registered. They reflect the inputs one clock edge after the inputs change. While `rst_n` is low, the outputs are `pend_id`=1023 with both lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_enable | input | NUM_SRC | Per-source enable |
| src_pending | input | NUM_SRC | Per-source pending flag |
| src_group | input | NUM_SRC | Per-source group (0 or 1) |
| src_targets | input | NUM_SRC*CPU_COUNT | Per-source processor target masks |
| src_prio | input | NUM_SRC*8 | Per-source priorities, lower value is more urgent |
| dist_grp_en | input | 2 | Distributor enables, bit g for group g |
| cpu_grp_en | input | 2 | CPU interface enables, bit g for group g |
| fast_route_en | input | 1 | Route group 0 to the fast request line |
| prio_mask | input | 8 | Priority mask |
| run_prio | input | 9 | Running priority, 256 when idle |
| pend_id | output | 10 | Highest pending ID, 1023 when none |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Every result is due exactly one rising edge after its stimulus, because the arbitration is combinational into a single output register. The bench changes inputs on a falling edge and reads the outputs on the next falling edge, which is one rising edge later. A dedicated latency test also reads the outputs just after the stimulus and before that edge, and expects them still to hold the old values. This proves the update is registered rather than combinational.

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int NUM_SRC   = 64,
  parameter int CPU_COUNT = 8,
  parameter int CPU_IDX   = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           src_enable,
  input  logic [NUM_SRC-1:0]           src_pending,
  input  logic [NUM_SRC-1:0]           src_group,
  input  logic [NUM_SRC*CPU_COUNT-1:0] src_targets,
  input  logic [NUM_SRC*8-1:0]         src_prio,
  input  logic [1:0]                   dist_grp_en,
  input  logic [1:0]                   cpu_grp_en,
  input  logic                         fast_route_en,
  input  logic [7:0]                   prio_mask,
  input  logic [8:0]                   run_prio,
  output logic [9:0]                   pend_id,
  output logic                         irq_o,
  output logic                         fiq_o
);
  localparam int          PRIVATE_N = 32;
  localparam logic [9:0]  NO_ID     = 10'd1023;
  localparam logic [8:0]  IDLE_PRIO = 9'h100;

  logic [8:0] win_prio;
  logic [9:0] win_id;
  logic       win_grp;

  always_comb begin
    win_prio = IDLE_PRIO;
    win_id   = NO_ID;
    win_grp  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_enable[i] && src_pending[i] &&
          (i < PRIVATE_N || src_targets[i*CPU_COUNT + CPU_IDX]) &&
          {1'b0, src_prio[i*8 +: 8]} < win_prio) begin
        win_prio = {1'b0, src_prio[i*8 +: 8]};
        win_id   = 10'(i);
        win_grp  = src_group[i];
      end
    end
  end

  logic shown, grp_ok, deliver, use_fast;
  assign shown    = win_prio < {1'b0, prio_mask};
  assign grp_ok   = dist_grp_en[win_grp] && cpu_grp_en[win_grp];
  assign deliver  = shown && (win_prio < run_prio) && grp_ok;
  assign use_fast = !win_grp && fast_route_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_id <= NO_ID;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
    end else begin
      pend_id <= shown ? win_id : NO_ID;
      irq_o   <= deliver && !use_fast;
      fiq_o   <= deliver && use_fast;
    end
  end
endmodule

module irq_prio_select_chk #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_enable,
  input logic [NUM_SRC-1:0] src_pending,
  input logic [1:0]         dist_grp_en,
  input logic [1:0]         cpu_grp_en,
  input logic               fast_route_en,
  input logic [9:0]         pend_id,
  input logic               irq_o,
  input logic               fiq_o
);
  assert_lines_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));
  assert_fast_needs_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!fiq_o || $past(fast_route_en)));
  assert_dist_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dist_grp_en == 2'b00 || cpu_grp_en == 2'b00) |=> (!irq_o && !fiq_o));
  assert_idle_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (~|(src_enable & src_pending)) |=> (pend_id == 10'd1023 && !irq_o && !fiq_o));
  assert_req_has_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> (pend_id != 10'd1023));
endmodule

bind irq_prio_select irq_prio_select_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_enable(src_enable), .src_pending(src_pending),
  .dist_grp_en(dist_grp_en), .cpu_grp_en(cpu_grp_en), .fast_route_en(fast_route_en),
  .pend_id(pend_id), .irq_o(irq_o), .fiq_o(fiq_o));

// File: tb/irq_prio_select_test.sv
module irq_prio_select_test;
  localparam int NS = 64;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0]    en, pend, grp;
  logic [NS*NC-1:0] tgt;
  logic [NS*8-1:0]  prio;
  logic [1:0]       dge, cge;
  logic             fast;
  logic [7:0]       pmask;
  logic [8:0]       rprio;
  logic [9:0]       pend_id;
  logic             irq_o, fiq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_prio_select #(.NUM_SRC(NS), .CPU_COUNT(NC), .CPU_IDX(0)) uut (
    .clk(clk), .rst_n(rst_n), .src_enable(en), .src_pending(pend), .src_group(grp),
    .src_targets(tgt), .src_prio(prio), .dist_grp_en(dge), .cpu_grp_en(cge),
    .fast_route_en(fast), .prio_mask(pmask), .run_prio(rprio),
    .pend_id(pend_id), .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic expect_out(input logic [9:0] id, input logic irq, input logic fiq,
                            input string tag);
    checks++;
    if (pend_id !== id || irq_o !== irq || fiq_o !== fiq) begin
      fails++;
      $display("FAIL %s: got id=%0d irq=%0b fiq=%0b, expected id=%0d irq=%0b fiq=%0b",
               tag, pend_id, irq_o, fiq_o, id, irq, fiq);
    end
  endtask

  task automatic defaults();
    en = '0; pend = '0; grp = '0; tgt = '0; prio = '1;
    dge = 2'b11; cge = 2'b11; fast = 1'b0; pmask = 8'hFF; rprio = 9'h100;
  endtask

  task automatic put(input int i, input logic g, input logic [7:0] p, input logic t);
    en[i] = 1'b1; pend[i] = 1'b1; grp[i] = g; prio[i*8 +: 8] = p;
    tgt[i*NC +: NC] = {7'b0, t};
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; defaults(); put(3, 0, 8'h10, 0);
    @(negedge clk); @(negedge clk);
    expect_out(10'd1023, 0, 0, "R9 reset state");
    rst_n = 1'b1;
    @(negedge clk); defaults();
  endtask

  task automatic t_candidate();
    defaults(); put(40, 1, 8'h20, 0); settle();
    expect_out(10'd1023, 0, 0, "R1 shared source not targeted");
    tgt[40*NC +: NC] = 8'b0000_0010; settle();
    expect_out(10'd1023, 0, 0, "R1 targets another cpu only");
    tgt[40*NC] = 1'b1; settle();
    expect_out(10'd40, 1, 0, "R1 shared source targeted");
    defaults(); put(5, 1, 8'h20, 0); settle();
    expect_out(10'd5, 1, 0, "R1 private source without target");
    pend[5] = 1'b0; settle();
    expect_out(10'd1023, 0, 0, "R1 enabled but not pending");
  endtask

  task automatic t_winner();
    defaults(); put(10, 1, 8'h40, 0); put(50, 1, 8'h20, 1); settle();
    expect_out(10'd50, 1, 0, "R2 lower priority value wins");
    defaults(); put(12, 1, 8'h30, 0); put(7, 1, 8'h30, 0); put(60, 1, 8'h30, 1); settle();
    expect_out(10'd7, 1, 0, "R2 tie goes to lowest id");
    defaults(); put(63, 1, 8'h00, 1); put(0, 1, 8'h01, 0); settle();
    expect_out(10'd63, 1, 0, "R2 priority zero at top id");
  endtask

  task automatic t_empty();
    defaults(); en = '1; settle();
    expect_out(10'd1023, 0, 0, "R3 nothing pending");
    defaults(); pend = '1; pmask = 8'hFF; settle();
    expect_out(10'd1023, 0, 0, "R3 nothing enabled");
  endtask

  task automatic t_mask();
    defaults(); put(20, 1, 8'h80, 0); pmask = 8'h80; settle();
    expect_out(10'd1023, 0, 0, "R4 priority equal to mask hidden");
    pmask = 8'h81; settle();
    expect_out(10'd20, 1, 0, "R4 priority below mask shown");
    defaults(); put(20, 1, 8'hFF, 0); pmask = 8'hFF; settle();
    expect_out(10'd1023, 0, 0, "R4 priority 255 never below mask");
  endtask

  task automatic t_running();
    defaults(); put(9, 1, 8'h40, 0); rprio = 9'h040; settle();
    expect_out(10'd9, 0, 0, "R5 equal to running priority");
    rprio = 9'h041; settle();
    expect_out(10'd9, 1, 0, "R5 below running priority");
  endtask

  task automatic t_groups();
    defaults(); put(33, 1, 8'h10, 1); dge = 2'b01; settle();
    expect_out(10'd33, 0, 0, "R6 distributor group1 off");
    dge = 2'b11; cge = 2'b01; settle();
    expect_out(10'd33, 0, 0, "R6 cpu group1 off");
    defaults(); put(33, 0, 8'h10, 1); cge = 2'b10; settle();
    expect_out(10'd33, 0, 0, "R6 cpu group0 off");
    dge = 2'b01; cge = 2'b01; settle();
    expect_out(10'd33, 1, 0, "R6 group0 both enabled");
  endtask

  task automatic t_fast();
    defaults(); put(2, 0, 8'h10, 0); fast = 1'b1; settle();
    expect_out(10'd2, 0, 1, "R7 group0 to fast line");
    grp[2] = 1'b1; settle();
    expect_out(10'd2, 1, 0, "R7 group1 stays normal");
    grp[2] = 1'b0; fast = 1'b0; settle();
    expect_out(10'd2, 1, 0, "R7 group0 without fast routing");
  endtask

  task automatic t_global_off();
    defaults(); put(2, 0, 8'h10, 0); fast = 1'b1; dge = 2'b00; settle();
    expect_out(10'd2, 0, 0, "R8 distributor all off");
    dge = 2'b11; cge = 2'b00; settle();
    expect_out(10'd2, 0, 0, "R8 cpu interface all off");
  endtask

  task automatic t_latency();
    defaults(); settle();
    put(44, 1, 8'h05, 1);
    #1;
    expect_out(10'd1023, 0, 0, "R9 no change before edge");
    settle();
    expect_out(10'd44, 1, 0, "R9 updated after one edge");
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_candidate();
    t_winner();
    t_empty();
    t_mask();
    t_running();
    t_groups();
    t_fast();
    t_global_off();
    t_latency();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule